// File: doc/BRIEF.md
# Privileged Instruction Permission Checker

This block judges, one request at a time, whether a privileged instruction may proceed on a core that has an optional hypervisor extension. The instructions covered are wait-for-interrupt, the address-translation fence, the two hypervisor fences (virtual and guest-physical), and the hypervisor virtual-machine load, store and execute-permission load. The decode stage supplies the instruction class with the current privilege level, the virtualization flag, the relevant trap-control bits from the machine and hypervisor status registers, and the access size code. One cycle later the block returns a single verdict: proceed, illegal-instruction fault or virtual-instruction fault.

When the verdict is proceed, side-effect strobes name the action the core takes. A halt request comes from wait-for-interrupt, a fence request from any of the three fences, and a two-stage-lookup enable covers the permitted hypervisor access only. The block does no memory access, holds no translation cache and does not handle wake-up from halt.

Top module: `priv_perm_check`

## Requirements
- R1: Every request (reqValid high at a rising edge) produces outValid high on the next rising edge. When outValid is low, every verdict and action output is low. Reset clears all outputs.
- R2: Whenever outValid is high, exactly one of allow, illegalFault and virtFault is high.
- R3: Wait-for-interrupt (class 0) gives virtFault when virtOn is set, or in supervisor mode with statusTw set. Otherwise it gives allow with haltReq. Privilege codes are 0 user, 1 supervisor, 3 machine.
- R4: The translation fence (class 1) gives illegalFault in user mode, or in supervisor mode with statusTvm set. Failing that, it gives virtFault when hypPresent, virtOn and hypVtvm are all set. Otherwise it gives allow with fenceReq.
- R5: The virtual hypervisor fence (class 2) gives virtFault in virtualized supervisor mode and allow with fenceReq in machine mode or non-virtualized supervisor mode. Every other case gives illegalFault.
- R6: The guest-physical hypervisor fence (class 3) gives illegalFault in non-virtualized supervisor mode with statusTvm set. Otherwise it behaves exactly as class 2.
- R7: The hypervisor load (class 4), store (class 5) and execute-permission load (class 6) are permitted in machine mode, in non-virtualized supervisor mode, and in non-virtualized user mode with hypUserAccess set. A permitted access with a legal size gives allow together with twoStageEn. twoStageEn is never high for any other class.
- R8: A hypervisor access that is not permitted gives virtFault when virtOn is set and illegalFault otherwise. This holds whatever the size code.
- R9: For classes 4 and 5, size codes 0 to 6 are legal: 0 signed byte, 1 unsigned byte, 2 signed half, 3 unsigned half, 4 signed word, 5 unsigned word, 6 doubleword. Code 7 on a permitted access gives illegalFault.
- R10: Class 6 accepts only size codes 3 (unsigned half) and 5 (unsigned word). Any other size on a permitted access gives illegalFault.
- R11: Class code 7 always gives illegalFault. Privilege code 2 is treated as user mode. haltReq is high only for class 0, and fenceReq only for classes 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| instClass | input | 3 | Instruction class code |
| privLevel | input | 2 | Current privilege level |
| virtOn | input | 1 | Hart is running virtualized |
| statusTw | input | 1 | Trap wait-for-interrupt bit |
| statusTvm | input | 1 | Trap virtual-memory bit |
| hypVtvm | input | 1 | Hypervisor trap-guest-fence bit |
| hypUserAccess | input | 1 | Hypervisor user access permit bit |
| hypPresent | input | 1 | Hypervisor extension present |
| memSize | input | 3 | Access size/sign code |
| outValid | output | 1 | Verdict valid, one cycle after request |
| allow | output | 1 | Instruction may proceed |
| twoStageEn | output | 1 | Two-stage lookup for this access |
| haltReq | output | 1 | Halt the hart |
| fenceReq | output | 1 | Flush translations |
| illegalFault | output | 1 | Illegal-instruction fault |
| virtFault | output | 1 | Virtual-instruction fault |

## Verification
A bad decision shows up at the ports on the cycle after the request. The symptoms are a wrong fault kind, two verdicts at once, or an action strobe without allow. Because the block holds no state across requests, every fault appears within one cycle of the request that exposes it and never carries over to the next. The most informative cases are the ones where rules overlap: a supervisor-mode wait with the wait-trap bit set, a guest fence blocked by the virtual-memory trap bit, a refused access carrying a bad size, and user mode with the hypervisor user access bit set. A full sweep of every input combination shows that no combination is left unjudged.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  localparam int CLASS_W = 3;
  localparam int PRIV_W  = 2;
  localparam int SIZE_W  = 3;
  localparam int SIZE_CODES = 1 << SIZE_W;

  typedef enum logic [CLASS_W-1:0] {
    OP_WAIT    = 3'd0,
    OP_VMFENCE = 3'd1,
    OP_HFENCEV = 3'd2,
    OP_HFENCEG = 3'd3,
    OP_HLOAD   = 3'd4,
    OP_HSTORE  = 3'd5,
    OP_HLOADX  = 3'd6,
    OP_RSVD    = 3'd7
  } opClass_e;

  localparam logic [PRIV_W-1:0] PRIV_USER = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_SUP  = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_MACH = 2'd3;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_LOADX = 2'd3
  } accKind_e;

  typedef struct packed {
    logic     permit;
    logic     faultIll;
    logic     faultVirt;
    logic     wantHalt;
    logic     wantFence;
    accKind_e accKind;
  } ctlStrobes_t;
endpackage

// File: rtl/pchk_ctrl.sv
module pchk_ctrl
  import pchk_pkg::*;
(
  input  logic [CLASS_W-1:0] instClass,
  input  logic [PRIV_W-1:0]  privLevel,
  input  logic               virtOn,
  input  logic               statusTw,
  input  logic               statusTvm,
  input  logic               hypVtvm,
  input  logic               hypUserAccess,
  input  logic               hypPresent,
  output ctlStrobes_t        strobes
);
  logic isMach, isSup, isUser;
  logic hypPermit;

  assign isMach = (privLevel == PRIV_MACH);
  assign isSup  = (privLevel == PRIV_SUP);
  assign isUser = !isMach && !isSup;   // code 2 folds onto user

  assign hypPermit = isMach || (isSup && !virtOn) ||
                     (isUser && !virtOn && hypUserAccess);

  // shared rule for both hypervisor fences
  function automatic ctlStrobes_t hfenceRule(input logic m, input logic s, input logic v);
    ctlStrobes_t r;
    r = '0;
    if (s && v) r.faultVirt = 1'b1;
    else if (m || s) begin
      r.permit    = 1'b1;
      r.wantFence = 1'b1;
    end else r.faultIll = 1'b1;
    return r;
  endfunction

  always_comb begin
    strobes = '0;
    unique case (opClass_e'(instClass))
      OP_WAIT: begin
        if ((isSup && statusTw) || virtOn) strobes.faultVirt = 1'b1;
        else begin
          strobes.permit   = 1'b1;
          strobes.wantHalt = 1'b1;
        end
      end
      OP_VMFENCE: begin
        if (isUser || (isSup && statusTvm)) strobes.faultIll = 1'b1;
        else if (hypPresent && virtOn && hypVtvm) strobes.faultVirt = 1'b1;
        else begin
          strobes.permit    = 1'b1;
          strobes.wantFence = 1'b1;
        end
      end
      OP_HFENCEV: strobes = hfenceRule(isMach, isSup, virtOn);
      OP_HFENCEG: begin
        if (isSup && !virtOn && statusTvm) strobes.faultIll = 1'b1;
        else strobes = hfenceRule(isMach, isSup, virtOn);
      end
      OP_HLOAD, OP_HSTORE, OP_HLOADX: begin
        if (hypPermit) begin
          strobes.permit  = 1'b1;
          strobes.accKind = (opClass_e'(instClass) == OP_HLOAD)  ? ACC_LOAD  :
                            (opClass_e'(instClass) == OP_HSTORE) ? ACC_STORE : ACC_LOADX;
        end else if (virtOn) strobes.faultVirt = 1'b1;
        else strobes.faultIll = 1'b1;
      end
      default: strobes.faultIll = 1'b1;
    endcase
  end
endmodule

// File: rtl/pchk_dpath.sv
module pchk_dpath
  import pchk_pkg::*;
#(
  parameter logic [SIZE_CODES-1:0] LOAD_SIZES  = 8'b0111_1111,
  parameter logic [SIZE_CODES-1:0] STORE_SIZES = 8'b0111_1111,
  parameter logic [SIZE_CODES-1:0] LOADX_SIZES = 8'b0010_1000
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SIZE_W-1:0] memSize,
  input  ctlStrobes_t       strobes,
  output logic              outValid,
  output logic              allow,
  output logic              twoStageEn,
  output logic              haltReq,
  output logic              fenceReq,
  output logic              illegalFault,
  output logic              virtFault
);
  logic [SIZE_CODES-1:0] sizeMask;
  logic sizeBad, allowNext;

  always_comb begin
    unique case (strobes.accKind)
      ACC_LOAD:  sizeMask = LOAD_SIZES;
      ACC_STORE: sizeMask = STORE_SIZES;
      ACC_LOADX: sizeMask = LOADX_SIZES;
      default:   sizeMask = '1;
    endcase
  end

  assign sizeBad   = (strobes.accKind != ACC_NONE) && !sizeMask[memSize];
  assign allowNext = strobes.permit && !sizeBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      allow        <= 1'b0;
      twoStageEn   <= 1'b0;
      haltReq      <= 1'b0;
      fenceReq     <= 1'b0;
      illegalFault <= 1'b0;
      virtFault    <= 1'b0;
    end else begin
      outValid     <= reqValid;
      allow        <= reqValid && allowNext;
      twoStageEn   <= reqValid && allowNext && (strobes.accKind != ACC_NONE);
      haltReq      <= reqValid && allowNext && strobes.wantHalt;
      fenceReq     <= reqValid && allowNext && strobes.wantFence;
      illegalFault <= reqValid && (strobes.faultIll || (strobes.permit && sizeBad));
      virtFault    <= reqValid && strobes.faultVirt;
    end
  end

  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $onehot({allow, illegalFault, virtFault}));
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(allow || twoStageEn || haltReq || fenceReq || illegalFault || virtFault));
  p_action_needs_allow_r11: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq || fenceReq || twoStageEn) |-> allow);
  p_single_action_r11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({haltReq, fenceReq, twoStageEn}) <= 1);
endmodule

// File: rtl/priv_perm_check.sv
module priv_perm_check
  import pchk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CLASS_W-1:0] instClass,
  input  logic [PRIV_W-1:0]  privLevel,
  input  logic               virtOn,
  input  logic               statusTw,
  input  logic               statusTvm,
  input  logic               hypVtvm,
  input  logic               hypUserAccess,
  input  logic               hypPresent,
  input  logic [SIZE_W-1:0]  memSize,
  output logic               outValid,
  output logic               allow,
  output logic               twoStageEn,
  output logic               haltReq,
  output logic               fenceReq,
  output logic               illegalFault,
  output logic               virtFault
);
  ctlStrobes_t strobes;

  pchk_ctrl u_ctrl (
    .instClass(instClass), .privLevel(privLevel), .virtOn(virtOn),
    .statusTw(statusTw), .statusTvm(statusTvm), .hypVtvm(hypVtvm),
    .hypUserAccess(hypUserAccess), .hypPresent(hypPresent), .strobes(strobes)
  );

  pchk_dpath u_dpath (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memSize(memSize),
    .strobes(strobes), .outValid(outValid), .allow(allow),
    .twoStageEn(twoStageEn), .haltReq(haltReq), .fenceReq(fenceReq),
    .illegalFault(illegalFault), .virtFault(virtFault)
  );

  // virtual fault only when virtualized, except the supervisor wait trap
  p_vfault_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    virtFault |-> ($past(virtOn) || $past(instClass) == OP_WAIT));
  p_user_vmfence_illegal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && instClass == OP_VMFENCE && privLevel == PRIV_USER) |=> illegalFault);
  p_halt_from_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> $past(instClass) == OP_WAIT);
  p_twostage_class_r7: assert property (@(posedge clk) disable iff (!rstN)
    twoStageEn |-> $past(instClass) inside {OP_HLOAD, OP_HSTORE, OP_HLOADX});
endmodule

// File: tb/tb_priv_perm_check.sv
`timescale 1ns/1ps
module tb_priv_perm_check;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] instClass = '0;
  logic [1:0] privLevel = '0;
  logic virtOn = 0, statusTw = 0, statusTvm = 0, hypVtvm = 0, hypUserAccess = 0, hypPresent = 0;
  logic [2:0] memSize = '0;
  logic outValid, allow, twoStageEn, haltReq, fenceReq, illegalFault, virtFault;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  priv_perm_check dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .instClass(instClass),
    .privLevel(privLevel), .virtOn(virtOn), .statusTw(statusTw),
    .statusTvm(statusTvm), .hypVtvm(hypVtvm), .hypUserAccess(hypUserAccess),
    .hypPresent(hypPresent), .memSize(memSize), .outValid(outValid),
    .allow(allow), .twoStageEn(twoStageEn), .haltReq(haltReq),
    .fenceReq(fenceReq), .illegalFault(illegalFault), .virtFault(virtFault)
  );

  // expected bits: {allow, twoStageEn, haltReq, fenceReq, illegalFault, virtFault}
  localparam logic [5:0] E_HALT = 6'b101000, E_FENCE = 6'b100100,
                         E_HYP = 6'b110000, E_ILL = 6'b000010, E_VF = 6'b000001;

  typedef struct packed {
    logic [2:0] cls; logic [1:0] prv; logic vir, tw, tvm, vtvm, hu, hyp;
    logic [2:0] sz; logic [5:0] exp;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 2'd1, 0,1,0,0,0,0, 3'd0, E_VF},    // R3 sup + tw
    '{3'd0, 2'd0, 0,1,0,0,0,0, 3'd0, E_HALT},  // R3 user + tw
    '{3'd0, 2'd3, 1,0,0,0,0,0, 3'd0, E_VF},    // R3 virt
    '{3'd0, 2'd3, 0,1,0,0,0,0, 3'd0, E_HALT},  // R3 mach
    '{3'd1, 2'd0, 0,0,0,0,0,1, 3'd0, E_ILL},   // R4 user
    '{3'd1, 2'd1, 0,0,1,0,0,1, 3'd0, E_ILL},   // R4 sup tvm
    '{3'd1, 2'd1, 1,0,0,1,0,1, 3'd0, E_VF},    // R4 vtvm
    '{3'd1, 2'd1, 1,0,0,1,0,0, 3'd0, E_FENCE}, // R4 no hyp ext
    '{3'd1, 2'd3, 0,0,1,0,0,1, 3'd0, E_FENCE}, // R4 mach
    '{3'd2, 2'd1, 1,0,0,0,0,1, 3'd0, E_VF},    // R5
    '{3'd2, 2'd0, 0,0,0,0,0,1, 3'd0, E_ILL},   // R5
    '{3'd2, 2'd0, 1,0,0,0,0,1, 3'd0, E_ILL},   // R5
    '{3'd2, 2'd3, 1,0,0,0,0,1, 3'd0, E_FENCE}, // R5
    '{3'd3, 2'd1, 0,0,1,0,0,1, 3'd0, E_ILL},   // R6
    '{3'd3, 2'd1, 0,0,0,0,0,1, 3'd0, E_FENCE}, // R6
    '{3'd3, 2'd1, 1,0,1,0,0,1, 3'd0, E_VF},    // R6
    '{3'd4, 2'd0, 0,0,0,0,1,1, 3'd0, E_HYP},   // R7 user hu
    '{3'd4, 2'd0, 0,0,0,0,0,1, 3'd0, E_ILL},   // R8
    '{3'd4, 2'd0, 1,0,0,0,1,1, 3'd0, E_VF},    // R8
    '{3'd5, 2'd1, 0,0,0,0,0,1, 3'd6, E_HYP},   // R9 doubleword
    '{3'd5, 2'd1, 0,0,0,0,0,1, 3'd7, E_ILL},   // R9 bad size
    '{3'd6, 2'd3, 0,0,0,0,0,1, 3'd3, E_HYP},   // R10
    '{3'd6, 2'd3, 0,0,0,0,0,1, 3'd4, E_ILL},   // R10
    '{3'd6, 2'd1, 1,0,0,0,0,1, 3'd3, E_VF},    // R8
    '{3'd7, 2'd3, 0,0,0,0,0,1, 3'd0, E_ILL},   // R11 reserved class
    '{3'd4, 2'd2, 0,0,0,0,1,1, 3'd0, E_HYP},   // R11 priv 2 as user
    '{3'd4, 2'd2, 0,0,0,0,0,1, 3'd0, E_ILL},   // R11
    '{3'd5, 2'd1, 1,0,0,0,0,1, 3'd7, E_VF}     // R8 refusal before size
  };

  function automatic logic [5:0] model(input logic [2:0] c, input logic [1:0] p,
      input logic v, tw, tvm, vtvm, hu, hyp, input logic [2:0] sz);
    logic m, s, u, ok, szOk;
    m = (p == 2'd3); s = (p == 2'd1); u = !m && !s;
    case (c)
      3'd0: return ((s && tw) || v) ? E_VF : E_HALT;
      3'd1: begin
        if (u || (s && tvm)) return E_ILL;
        if (hyp && v && vtvm) return E_VF;
        return E_FENCE;
      end
      3'd2, 3'd3: begin
        if (c == 3'd3 && s && !v && tvm) return E_ILL;
        if (s && v) return E_VF;
        if (m || s) return E_FENCE;
        return E_ILL;
      end
      3'd4, 3'd5, 3'd6: begin
        ok = m || (s && !v) || (u && !v && hu);
        if (!ok) return v ? E_VF : E_ILL;
        szOk = (c == 3'd6) ? (sz == 3'd3 || sz == 3'd5) : (sz != 3'd7);
        return szOk ? E_HYP : E_ILL;
      end
      default: return E_ILL;
    endcase
  endfunction

  task automatic checkOut(input logic expValid, input logic [5:0] exp, input string req);
    logic [5:0] act;
    act = {allow, twoStageEn, haltReq, fenceReq, illegalFault, virtFault};
    checks++;
    if (outValid !== expValid || act !== exp) begin
      fails++;
      $display("FAIL %s: got valid=%b out=%b, expected valid=%b out=%b", req, outValid, act, expValid, exp);
    end
  endtask

  task automatic apply(input vec_t t, input string req);
    @(negedge clk);
    reqValid = 1; instClass = t.cls; privLevel = t.prv; virtOn = t.vir;
    statusTw = t.tw; statusTvm = t.tvm; hypVtvm = t.vtvm; hypUserAccess = t.hu;
    hypPresent = t.hyp; memSize = t.sz;
    @(negedge clk);
    reqValid = 0;
    checkOut(1'b1, t.exp, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t t;
    repeat (3) @(negedge clk);
    checkOut(1'b0, 6'b0, "R1 reset state");
    rstN = 1;
    @(negedge clk);
    checkOut(1'b0, 6'b0, "R1 idle after reset");

    for (int i = 0; i < NV; i++) apply(TBL[i], "R2-table vector");

    // exhaustive sweep against the requirement model
    for (int k = 0; k < 16384; k++) begin
      t.cls = k[2:0]; t.prv = k[4:3]; t.vir = k[5]; t.tw = k[6]; t.tvm = k[7];
      t.vtvm = k[8]; t.hu = k[9]; t.hyp = k[10]; t.sz = k[13:11];
      t.exp = model(t.cls, t.prv, t.vir, t.tw, t.tvm, t.vtvm, t.hu, t.hyp, t.sz);
      apply(t, "R2 R7 R9 R10 sweep");
    end

    // idle cycle: no request gives quiet outputs (R1)
    @(negedge clk);
    checkOut(1'b0, 6'b0, "R1 no request");

    // request cut by reset clears outputs (R1)
    @(negedge clk);
    reqValid = 1; instClass = 3'd0; privLevel = 2'd3; virtOn = 0; statusTw = 0;
    rstN = 0;
    @(negedge clk);
    checkOut(1'b0, 6'b0, "R1 reset over request");
    reqValid = 0; rstN = 1;
    @(negedge clk);
    checkOut(1'b0, 6'b0, "R1 after reset release");

    // back-to-back requests (R1, R3, R5)
    @(negedge clk);
    reqValid = 1; instClass = 3'd0; privLevel = 2'd3; virtOn = 0;
    @(negedge clk);
    checkOut(1'b1, E_HALT, "R3 back-to-back first");
    instClass = 3'd2; privLevel = 2'd1; virtOn = 1;
    @(negedge clk);
    reqValid = 0;
    checkOut(1'b1, E_VF, "R5 back-to-back second");
    @(negedge clk);
    checkOut(1'b0, 6'b0, "R1 drop after burst");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule